// File: doc/BRIEF.md
# Stall-Switching Thread Issue Scheduler

This block is the issue controller of a multithreaded vector shader core. It keeps four hardware thread contexts, each with its own program counter and a state of idle, ready or stalled. On every clock it sends at most one instruction to a 32-lane vector unit, taken from one ready context. The instruction store sits outside the block. The block presents the program counter of the thread it picks, and the store returns that instruction's class and logical register index in the same cycle.

The scheduler stays on the current thread until that thread issues a texture fetch. The fetching thread then stalls for a fixed latency of 50 cycles, and issue moves to the next ready context in rotation. An end-of-program instruction sends a thread back to idle. A start request loads a program counter and makes an idle thread ready. When no context is ready, the block issues a bubble and counts it.

The block also maps registers. The pool of 16 vector registers is split statically, four per thread. Each issued logical register index is converted into a pool index, and any index outside the thread's slice is flagged.

Top module: `issue_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, no instruction is issued, every thread is idle, and the bubble counter reads zero.
- R2: At most one instruction issues per clock. While `issue_valid` is high, all 32 bits of `issue_lanes` are one; otherwise they are all zero.
- R3: A start request for an idle thread loads its program counter, and that thread may issue from the next cycle on. A start request for a thread that is ready or stalled is ignored.
- R4: The thread that issued last keeps issuing, one instruction per cycle with its program counter rising by one each time, until it stalls or ends.
- R5: Instruction class 2'b01 is a texture fetch. A thread that issues one at cycle t becomes stalled and issues next no earlier than cycle t+50.
- R6: When the current thread is not ready, issue goes to the first ready thread after it in the order T0, T1, T2, T3, T0.
- R7: Instruction class 2'b10 is end of program. It returns the thread to idle, and the thread issues nothing more until it is started again. Classes 2'b00 and 2'b11 are arithmetic.
- R8: In a cycle with no ready thread, `issue_valid` is low and the bubble counter rises by one at the next clock.
- R9: For an issued instruction with logical index below 4, `phys_reg` equals thread number times 4 plus the logical index.
- R10: An issued logical index of 4 or more raises `reg_err`, and `phys_reg` then reads zero.
- R11: When four threads each run 20 arithmetic instructions between texture fetches, no bubble occurs while all four are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start request |
| start_tid | input | 2 | Thread to start |
| start_pc | input | 8 | Initial program counter for the started thread |
| instr_op | input | 2 | Class of the instruction at `issue_pc`: 00 arith, 01 texture, 10 end, 11 arith |
| instr_lreg | input | 3 | Logical register index of that instruction |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_tid | output | 2 | Thread that issues |
| issue_pc | output | 8 | Program counter of the issued instruction |
| issue_lanes | output | 32 | Lane enables for the vector unit |
| phys_reg | output | 4 | Pool register index |
| reg_err | output | 1 | Logical index out of the thread's slice |
| idle_cycles | output | 16 | Count of bubble cycles |

## Verification
All four threads are started back to back, with a program of 20 arithmetic instructions and one fetch per segment, two segments per thread, and then an end. The first rotation shows that the switch happens only on a stall, in the stated order, with no bubbles (R11). The second pass ends threads whose fetch results come back with gaps between them. This tells the 50-cycle wakeup apart from an early or late one, because the resulting bubble run lengths are 6, 20 and 20. A start request aimed at a running thread, and one out-of-range register index in a single thread, separate the ignore rule and the error mapping from ordinary issue.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    OP_ALU  = 2'b00,
    OP_TEX  = 2'b01,
    OP_END  = 2'b10,
    OP_ALU2 = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    TS_IDLE  = 2'b00,
    TS_READY = 2'b01,
    TS_STALL = 2'b10
  } tstate_e;

  // pool index = thread slot base + logical offset
  function automatic int unsigned pool_index(int unsigned tid, int unsigned lreg,
                                             int unsigned per_thr);
    return tid * per_thr + lreg;
  endfunction

  // slot visited k steps after cur in the rotation
  function automatic int unsigned rot_step(int unsigned cur, int unsigned k,
                                           int unsigned n);
    return (cur + k) % n;
  endfunction
endpackage

// File: rtl/thr_ctx.sv
module thr_ctx
  import sched_pkg::*;
#(
  parameter int PC_W    = 8,
  parameter int TEX_LAT = 50
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [PC_W-1:0] start_pc_i,
  input  logic            issue_i,
  input  logic [1:0]      op_i,
  output logic            ready_o,
  output logic            stalled_o,
  output logic            idle_o,
  output logic [PC_W-1:0] pc_o
);
  localparam int TMR_W = $clog2(TEX_LAT + 1);

  tstate_e          st_q;
  logic [TMR_W-1:0] tmr_q;
  logic [PC_W-1:0]  pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= TS_IDLE;
      tmr_q <= '0;
      pc_q  <= '0;
    end else begin
      case (st_q)
        TS_IDLE: if (start_i) begin
          st_q <= TS_READY;
          pc_q <= start_pc_i;
        end
        TS_READY: if (issue_i) begin
          if (op_i == OP_END) begin
            st_q <= TS_IDLE;
          end else begin
            pc_q <= pc_q + 1'b1;
            if (op_i == OP_TEX) begin
              st_q  <= TS_STALL;
              tmr_q <= TMR_W'(TEX_LAT - 1);
            end
          end
        end
        TS_STALL: begin
          tmr_q <= tmr_q - 1'b1;
          if (tmr_q == TMR_W'(1)) st_q <= TS_READY;
        end
        default: st_q <= TS_IDLE;
      endcase
    end
  end

  assign ready_o   = (st_q == TS_READY);
  assign stalled_o = (st_q == TS_STALL);
  assign idle_o    = (st_q == TS_IDLE);
  assign pc_o      = pc_q;
endmodule

// File: rtl/rot_pick.sv
module rot_pick
  import sched_pkg::*;
#(
  parameter int NTHR  = 4,
  parameter int TID_W = 2
) (
  input  logic [TID_W-1:0] cur_i,
  input  logic [NTHR-1:0]  ready_i,
  output logic             valid_o,
  output logic [TID_W-1:0] tid_o
);
  always_comb begin
    valid_o = 1'b0;
    tid_o   = cur_i;
    for (int k = 0; k < NTHR; k++) begin
      if (!valid_o && ready_i[rot_step(int'(cur_i), k, NTHR)]) begin
        valid_o = 1'b1;
        tid_o   = TID_W'(rot_step(int'(cur_i), k, NTHR));
      end
    end
  end
endmodule

// File: rtl/reg_slice_map.sv
module reg_slice_map
  import sched_pkg::*;
#(
  parameter int TID_W   = 2,
  parameter int LREG_W  = 3,
  parameter int PREG_W  = 4,
  parameter int PER_THR = 4
) (
  input  logic              valid_i,
  input  logic [TID_W-1:0]  tid_i,
  input  logic [LREG_W-1:0] lreg_i,
  output logic [PREG_W-1:0] phys_o,
  output logic              err_o
);
  logic in_slice;
  assign in_slice = (int'(lreg_i) < PER_THR);
  assign err_o    = valid_i && !in_slice;
  assign phys_o   = (valid_i && in_slice)
                  ? PREG_W'(pool_index(int'(tid_i), int'(lreg_i), PER_THR)) : '0;
endmodule

// File: rtl/issue_sched.sv
module issue_sched
  import sched_pkg::*;
#(
  parameter int NTHR     = 4,
  parameter int LANES    = 32,
  parameter int REG_POOL = 16,
  parameter int TEX_LAT  = 50,
  parameter int PC_W     = 8,
  parameter int CNT_W    = 16,
  parameter int TID_W    = $clog2(NTHR),
  parameter int PREG_W   = $clog2(REG_POOL),
  parameter int LREG_W   = $clog2(REG_POOL / NTHR) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [TID_W-1:0]  start_tid,
  input  logic [PC_W-1:0]   start_pc,
  input  logic [1:0]        instr_op,
  input  logic [LREG_W-1:0] instr_lreg,
  output logic              issue_valid,
  output logic [TID_W-1:0]  issue_tid,
  output logic [PC_W-1:0]   issue_pc,
  output logic [LANES-1:0]  issue_lanes,
  output logic [PREG_W-1:0] phys_reg,
  output logic              reg_err,
  output logic [CNT_W-1:0]  idle_cycles
);
  localparam int PER_THR = REG_POOL / NTHR;

  logic [NTHR-1:0] thr_ready, thr_stalled, thr_idle;
  logic [PC_W-1:0] pc_arr [NTHR];
  logic [TID_W-1:0] cur_q, sel_tid;
  logic            sel_valid;
  logic            tex_evt, end_evt;

  for (genvar g = 0; g < NTHR; g++) begin : g_ctx
    thr_ctx #(.PC_W(PC_W), .TEX_LAT(TEX_LAT)) u_ctx (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_valid && (start_tid == TID_W'(g))),
      .start_pc_i(start_pc),
      .issue_i   (sel_valid && (sel_tid == TID_W'(g))),
      .op_i      (instr_op),
      .ready_o   (thr_ready[g]),
      .stalled_o (thr_stalled[g]),
      .idle_o    (thr_idle[g]),
      .pc_o      (pc_arr[g])
    );
  end

  rot_pick #(.NTHR(NTHR), .TID_W(TID_W)) u_pick (
    .cur_i  (cur_q),
    .ready_i(thr_ready),
    .valid_o(sel_valid),
    .tid_o  (sel_tid)
  );

  reg_slice_map #(.TID_W(TID_W), .LREG_W(LREG_W), .PREG_W(PREG_W),
                  .PER_THR(PER_THR)) u_map (
    .valid_i(sel_valid),
    .tid_i  (sel_tid),
    .lreg_i (instr_lreg),
    .phys_o (phys_reg),
    .err_o  (reg_err)
  );

  assign tex_evt = sel_valid && (instr_op == OP_TEX);
  assign end_evt = sel_valid && (instr_op == OP_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q       <= '0;
      idle_cycles <= '0;
    end else begin
      if (sel_valid) cur_q <= sel_tid;
      else           idle_cycles <= idle_cycles + 1'b1;
    end
  end

  assign issue_valid = sel_valid;
  assign issue_tid   = sel_tid;
  assign issue_pc    = pc_arr[sel_tid];
  assign issue_lanes = sel_valid ? '1 : '0;
endmodule

// File: rtl/issue_sched_chk.sv
module issue_sched_chk #(
  parameter int NTHR  = 4,
  parameter int TID_W = 2,
  parameter int PC_W  = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_valid,
  input logic [TID_W-1:0] issue_tid,
  input logic [PC_W-1:0]  issue_pc,
  input logic [1:0]       instr_op,
  input logic             reg_err,
  input logic [CNT_W-1:0] idle_cycles,
  input logic [NTHR-1:0]  thr_ready,
  input logic [NTHR-1:0]  thr_stalled,
  input logic [NTHR-1:0]  thr_idle
);
  logic arith_issue;
  assign arith_issue = issue_valid && (instr_op == 2'b00 || instr_op == 2'b11);

  AST_ISSUER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> thr_ready[issue_tid]); // R5

  AST_STAY_ON_THREAD: assert property (@(posedge clk) disable iff (!rst_n)
    arith_issue |=> issue_valid && issue_tid == $past(issue_tid)); // R4

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    arith_issue |=> issue_pc == $past(issue_pc) + 1'b1); // R4

  AST_TEX_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && instr_op == 2'b01) |=> thr_stalled[$past(issue_tid)]); // R5

  AST_END_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && instr_op == 2'b10) |=> thr_idle[$past(issue_tid)]); // R7

  AST_BUBBLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> idle_cycles == $past(idle_cycles) + 1'b1); // R8

  AST_NO_BUBBLE_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_ready != '0) |-> issue_valid); // R6

  AST_ERR_ONLY_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err |-> issue_valid); // R10
endmodule

bind issue_sched issue_sched_chk #(
  .NTHR(NTHR), .TID_W(TID_W), .PC_W(PC_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .issue_valid(issue_valid),
  .issue_tid  (issue_tid),
  .issue_pc   (issue_pc),
  .instr_op   (instr_op),
  .reg_err    (reg_err),
  .idle_cycles(idle_cycles),
  .thr_ready  (thr_ready),
  .thr_stalled(thr_stalled),
  .thr_idle   (thr_idle)
);

// File: tb/sim_issue_sched.sv
module sim_issue_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic [1:0]  start_tid = '0;
  logic [7:0]  start_pc = '0;
  logic [1:0]  instr_op;
  logic [2:0]  instr_lreg;
  logic        issue_valid;
  logic [1:0]  issue_tid;
  logic [7:0]  issue_pc;
  logic [31:0] issue_lanes;
  logic [3:0]  phys_reg;
  logic        reg_err;
  logic [15:0] idle_cycles;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  issue_sched u0 (.*);

  // Instruction store model: thread base at tid*64; offset 42 ends,
  // every 21st instruction (offset%21==20) is a fetch, the rest arithmetic.
  always_comb begin
    int off;
    off = int'(issue_pc) % 64;
    if (off == 42)          instr_op = 2'b10;
    else if (off % 21 == 20) instr_op = 2'b01;
    else                     instr_op = 2'b00;
    instr_lreg = (issue_tid == 2'd2 && off == 5) ? 3'd6 : 3'(off % 4);
  end

  typedef struct packed {
    logic       v;
    logic [1:0] tid;
    logic [7:0] pc;
    logic [3:0] phys;
    logic       err;
  } item_t;

  item_t exp_q[$];

  localparam int N_CYC = 226;

  // Expected issue at cycle c after T0 becomes ready (cycle 0).
  function automatic item_t expect_at(int c);
    item_t it;
    int seg, tid, off, idx;
    it = '0;
    tid = -1;
    off = 0;
    if (c < 168) begin
      seg = c / 21;
      tid = seg % 4;
      off = ((seg >= 4) ? 21 : 0) + c % 21;
    end else if (c == 168) begin tid = 0; off = 42; end
    else if (c == 175) begin tid = 1; off = 42; end
    else if (c == 196) begin tid = 2; off = 42; end
    else if (c == 217) begin tid = 3; off = 42; end
    if (tid >= 0) begin
      idx     = (tid == 2 && off == 5) ? 6 : off % 4;
      it.v    = 1'b1;
      it.tid  = 2'(tid);
      it.pc   = 8'(tid * 64 + off);
      it.err  = (idx >= 4);
      it.phys = it.err ? 4'd0 : 4'(tid * 4 + idx);
    end
    return it;
  endfunction

  task automatic push_expected();
    for (int c = 0; c < N_CYC; c++) exp_q.push_back(expect_at(c));
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_item(input int c, input item_t e);
    check(issue_valid == e.v, "R4 R6 R8", $sformatf("valid c%0d", c), issue_valid, e.v);
    check(issue_lanes == (e.v ? 32'hFFFF_FFFF : 32'h0), "R2",
          $sformatf("lanes c%0d", c), issue_lanes, e.v ? 32'hFFFF_FFFF : 0);
    if (e.v) begin
      check(issue_tid == e.tid, "R6", $sformatf("tid c%0d", c), issue_tid, e.tid);
      check(issue_pc == e.pc, "R3 R4 R5", $sformatf("pc c%0d", c), issue_pc, e.pc);
      check(phys_reg == e.phys, "R9", $sformatf("phys c%0d", c), phys_reg, e.phys);
      check(reg_err == e.err, "R10", $sformatf("err c%0d", c), reg_err, e.err);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(issue_valid == 1'b0, "R1", "valid in reset", issue_valid, 0);
    check(idle_cycles == 16'd0, "R1", "idle count in reset", idle_cycles, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(issue_valid == 1'b0, "R1", "valid after reset", issue_valid, 0);
    check(idle_cycles == 16'd1, "R8", "bubble count after reset", idle_cycles, 1);
    push_expected();
    // R3: start T0; it issues from the next cycle (cycle 0)
    start_valid = 1'b1; start_tid = 2'd0; start_pc = 8'd0;
    fork
      begin
        @(negedge clk); start_tid = 2'd1; start_pc = 8'd64;
        @(negedge clk); start_tid = 2'd2; start_pc = 8'd128;
        @(negedge clk); start_tid = 2'd3; start_pc = 8'd192;
        // R3: start aimed at a running thread is ignored
        @(negedge clk); start_tid = 2'd0; start_pc = 8'd200;
        @(negedge clk); start_valid = 1'b0;
      end
      begin
        int base_idle;
        base_idle = 0;
        for (int c = 0; c < N_CYC; c++) begin
          @(negedge clk);
          if (c == 0) base_idle = int'(idle_cycles);
          compare_item(c, exp_q.pop_front());
          // R11: no bubble through the fully loaded phase
          if (c == 168) check(int'(idle_cycles) == base_idle, "R11", "bubbles while loaded",
                              idle_cycles, base_idle);
          // R5 R7 R8: wakeup gaps after the end instructions give 6+20+20 bubbles
          if (c == 217) check(int'(idle_cycles) == base_idle + 46, "R8", "bubble total",
                              idle_cycles, base_idle + 46);
        end
        // R7: ended threads stay silent
        check(issue_valid == 1'b0, "R7", "idle after end", issue_valid, 0);
      end
    join
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule